// File: doc/BRIEF.md
# Equivalent-Time Comparator Digitizer Sequencer

This block turns one latched comparator and a reference DAC into an 8-bit digitizer for a repetitive input signal. A sweep walks the reference through 256 ascending levels. At each level it walks the sampling phase across one full capture period in 40 steps and latches the comparator once per phase. Per phase, it counts how many levels returned a high result. With a 250 MHz capture clock (4 ns period) and 100 ps phase steps, the 40 results form one period of the waveform at an effective 10 Gsps.

Software or a parent controller pulses `start`. The block then drives the DAC through a valid/ready transfer. After each transfer it waits a programmable settle time. It requests every phase step from an external phase shifter and waits for that shifter's acknowledge. When the sweep is complete it pulses `done`. It then delivers the 40 codes as a valid/ready stream.

On the result stream, back-pressure is allowed at any time. While `res_valid` is high and `res_ready` is low, the code, the phase index and the last flag hold still. A beat transfers on a clock edge where both signals are high.

Top module: `ets_sampler_seq`

## Requirements
- R1: A `start` pulse while idle begins a sweep. `busy` stays high from the next cycle until the last result is accepted. A `start` that arrives while `busy` is high is ignored: no extra DAC transfer, no restart and no new sweep afterwards.
- R2: Levels L = 0..255 are offered in ascending order, one DAC transfer per level, with `dac_code` = L * 16 (the level in bits 11:4, zeros below). While `dac_valid` is high and `dac_ready` is low, the code holds stable.
- R3: The first `cmp_latch` after a DAC transfer edge begins exactly `settle_cycles` + 1 clock cycles after that edge. `settle_cycles` is captured when the sweep starts.
- R4: Within each level, phases 0..39 are sampled in order. After every sample the block raises `phase_req` and holds it until `phase_ack`, so each level issues 40 steps and the 40th returns the shifter to phase 0. No sample is taken while a step is outstanding.
- R5: `cmp_latch` is a one-cycle pulse, and `cmp_in` is taken in that cycle.
- R6: The code for a phase equals the number of levels whose latched result was high, saturated at 255.
- R7: `done` is a one-cycle pulse, given exactly once per sweep. It comes only after the step that follows the last phase of level 255 is acknowledged, and before any result is valid.
- R8: Results leave through a valid/ready stream in phase order 0..39, with `res_phase` equal to the index and `res_last` high only on phase 39. Code, phase and last flag stay stable under back-pressure.
- R9: All 40 counts are cleared when a sweep starts, so results never carry over from an earlier sweep.
- R10: After reset, `busy`, `done`, `dac_valid`, `phase_req`, `cmp_latch` and `res_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep when idle |
| settle_cycles | input | 6 | DAC settle wait, captured at start |
| busy | output | 1 | Sweep or result drain in progress |
| done | output | 1 | One-cycle pulse when all points are evaluated |
| dac_code | output | 12 | Reference DAC code |
| dac_valid | output | 1 | DAC code offered |
| dac_ready | input | 1 | DAC accepts the code |
| phase_req | output | 1 | Request one phase step |
| phase_ack | input | 1 | Phase step completed |
| cmp_latch | output | 1 | Latch strobe to the comparator |
| cmp_in | input | 1 | Comparator result |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Result consumer ready |
| res_code | output | 8 | Sample code for the phase |
| res_phase | output | 6 | Phase index of the beat |
| res_last | output | 1 | Final beat of the sweep |

## Verification
A counter that increments into the wrong phase slot, or that wraps instead of saturating, shows up as a wrong `res_code` on that phase's beat. That beat appears only after the whole sweep of about forty thousand cycles, so the bench compares every code against a comparator model with known thresholds, including thresholds of 0, 255 and 256. A level or phase counter that goes astray shows earlier, at the ports: a wrong `dac_code` on the next transfer, a wrong number of step requests per level, or a `done` that comes early or twice. A wrong settle count shows as a misplaced first latch after the very first DAC transfer.

// File: rtl/ets_seq_pkg.sv
package ets_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SETTLE,
    S_SAMPLE,
    S_STEP,
    S_FLAG,
    S_DRAIN
  } seq_state_t;
endpackage

// File: rtl/ets_sweep_ctrl.sv
module ets_sweep_ctrl
  import ets_seq_pkg::*;
#(
  parameter int NUM_PHASES = 40,
  parameter int CODE_W     = 8,
  parameter int DAC_W      = 12,
  parameter int SETTLE_W   = 6,
  localparam int PH_W      = $clog2(NUM_PHASES),
  localparam int DAC_SHIFT = DAC_W - CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                dac_ready,
  input  logic                phase_ack,
  input  logic                drain_done,
  output logic [DAC_W-1:0]    dac_code,
  output logic                dac_valid,
  output logic                phase_req,
  output logic                cmp_latch,
  output logic [PH_W-1:0]     phase_idx,
  output logic                clear_counts,
  output logic                done,
  output logic                busy
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NUM_PHASES - 1);

  seq_state_t          state;
  logic [CODE_W-1:0]   level;
  logic [SETTLE_W-1:0] settle_q;
  logic [SETTLE_W-1:0] settle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      level      <= '0;
      phase_idx  <= '0;
      settle_q   <= '0;
      settle_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          settle_q  <= settle_cycles;
          level     <= '0;
          phase_idx <= '0;
          state     <= S_LOAD;
        end
        S_LOAD: if (dac_ready) begin
          settle_cnt <= settle_q;
          state      <= S_SETTLE;
        end
        S_SETTLE: begin
          if (settle_cnt == '0) state <= S_SAMPLE;
          else settle_cnt <= settle_cnt - 1'b1;
        end
        S_SAMPLE: state <= S_STEP;
        S_STEP: if (phase_ack) begin
          if (phase_idx == PH_LAST) begin
            phase_idx <= '0;
            if (level == '1) state <= S_FLAG;
            else begin
              level <= level + 1'b1;
              state <= S_LOAD;
            end
          end else begin
            phase_idx <= phase_idx + 1'b1;
            state     <= S_SAMPLE;
          end
        end
        S_FLAG:  state <= S_DRAIN;
        S_DRAIN: if (drain_done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dac_code     = DAC_W'(level) << DAC_SHIFT;
    dac_valid    = (state == S_LOAD);
    phase_req    = (state == S_STEP);
    cmp_latch    = (state == S_SAMPLE);
    done         = (state == S_FLAG);
    busy         = (state != S_IDLE);
    clear_counts = (state == S_IDLE) && start;
  end

  assert_dac_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid && !dac_ready |=> dac_valid && $stable(dac_code))
    else $error("DAC code changed before acceptance");

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_req && !phase_ack |=> phase_req && !cmp_latch)
    else $error("phase request dropped before acknowledge");

  assert_latch_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_latch |=> !cmp_latch)
    else $error("latch strobe longer than one cycle");

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && busy)
    else $error("done not a single pulse");
endmodule

// File: rtl/ets_hit_counters.sv
module ets_hit_counters #(
  parameter int NUM_PHASES = 40,
  parameter int CODE_W     = 8,
  localparam int PH_W      = $clog2(NUM_PHASES)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clear,
  input  logic                                 hit,
  input  logic [PH_W-1:0]                      phase_idx,
  output logic [NUM_PHASES-1:0][CODE_W-1:0]    codes
);
  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_cnt
    logic [CODE_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n || clear) cnt <= '0;
      else if (hit && phase_idx == PH_W'(p) && cnt != '1) cnt <= cnt + 1'b1;
    end

    assign codes[p] = cnt;

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '1) && !clear |=> cnt == '1)
      else $error("phase counter wrapped");
  end
endmodule

// File: rtl/ets_result_stream.sv
module ets_result_stream #(
  parameter int NUM_PHASES = 40,
  parameter int CODE_W     = 8,
  localparam int PH_W      = $clog2(NUM_PHASES)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load,
  input  logic [NUM_PHASES-1:0][CODE_W-1:0] codes,
  input  logic                              res_ready,
  output logic                              res_valid,
  output logic [CODE_W-1:0]                 res_code,
  output logic [PH_W-1:0]                   res_phase,
  output logic                              res_last,
  output logic                              drain_done
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NUM_PHASES - 1);

  logic            active;
  logic [PH_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (load) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active && res_ready) begin
      if (idx == PH_LAST) active <= 1'b0;
      else idx <= idx + 1'b1;
    end
  end

  always_comb begin
    res_valid  = active;
    res_code   = codes[idx];
    res_phase  = idx;
    res_last   = (idx == PH_LAST);
    drain_done = active && res_ready && res_last;
  end

  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_code) && $stable(res_phase) && $stable(res_last))
    else $error("result changed under back-pressure");
endmodule

// File: rtl/ets_sampler_seq.sv
module ets_sampler_seq #(
  parameter int NUM_PHASES = 40,
  parameter int CODE_W     = 8,
  parameter int DAC_W      = 12,
  parameter int SETTLE_W   = 6,
  localparam int PH_W      = $clog2(NUM_PHASES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                busy,
  output logic                done,
  output logic [DAC_W-1:0]    dac_code,
  output logic                dac_valid,
  input  logic                dac_ready,
  output logic                phase_req,
  input  logic                phase_ack,
  output logic                cmp_latch,
  input  logic                cmp_in,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [CODE_W-1:0]   res_code,
  output logic [PH_W-1:0]     res_phase,
  output logic                res_last
);
  logic                              clear_counts;
  logic                              drain_done;
  logic [PH_W-1:0]                   phase_idx;
  logic [NUM_PHASES-1:0][CODE_W-1:0] codes;

  ets_sweep_ctrl #(
    .NUM_PHASES(NUM_PHASES), .CODE_W(CODE_W), .DAC_W(DAC_W), .SETTLE_W(SETTLE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .dac_ready(dac_ready), .phase_ack(phase_ack), .drain_done(drain_done),
    .dac_code(dac_code), .dac_valid(dac_valid), .phase_req(phase_req),
    .cmp_latch(cmp_latch), .phase_idx(phase_idx), .clear_counts(clear_counts),
    .done(done), .busy(busy)
  );

  ets_hit_counters #(.NUM_PHASES(NUM_PHASES), .CODE_W(CODE_W)) u_counts (
    .clk(clk), .rst_n(rst_n), .clear(clear_counts),
    .hit(cmp_latch && cmp_in), .phase_idx(phase_idx), .codes(codes)
  );

  ets_result_stream #(.NUM_PHASES(NUM_PHASES), .CODE_W(CODE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(done), .codes(codes), .res_ready(res_ready),
    .res_valid(res_valid), .res_code(res_code), .res_phase(res_phase),
    .res_last(res_last), .drain_done(drain_done)
  );

  assert_done_before_results_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !res_valid && !phase_req)
    else $error("done overlaps results or a pending step");

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dac_valid && !phase_req && !cmp_latch && !res_valid)
    else $error("activity while idle");
endmodule

// File: tb/test_ets_sampler_seq.sv
module test_ets_sampler_seq;
  localparam int NPH = 40;
  localparam int NLV = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] settle_in = '0;
  logic       busy, done, dac_valid, phase_req, cmp_latch, res_valid, res_last;
  logic [11:0] dac_code;
  logic [7:0] res_code;
  logic [5:0] res_phase;
  logic       dac_ready = 1'b0, phase_ack = 1'b0, cmp_in = 1'b0, res_ready = 1'b0;

  always #4 clk = ~clk;

  ets_sampler_seq i_ets_sampler_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_in),
    .busy(busy), .done(done), .dac_code(dac_code), .dac_valid(dac_valid),
    .dac_ready(dac_ready), .phase_req(phase_req), .phase_ack(phase_ack),
    .cmp_latch(cmp_latch), .cmp_in(cmp_in), .res_valid(res_valid),
    .res_ready(res_ready), .res_code(res_code), .res_phase(res_phase),
    .res_last(res_last)
  );

  int n_checks = 0, n_fail = 0;
  int mode = 0;
  int thr [NPH];
  int lvl_b, ph_b, hs_cnt, latch_cnt, ack_cnt, done_cnt, rx_idx;
  int gap, ack_wait, settle_bad, dac_bad, order_bad, rx_bad;
  bit gap_armed, finished = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit cmp_model(int lvl, int ph);
    if (mode == 0) return lvl < thr[ph];
    return ((lvl * 7 + ph * 13) % 5) == 0;
  endfunction

  function automatic int exp_code(int ph);
    int n = 0;
    for (int l = 0; l < NLV; l++) n += int'(cmp_model(l, ph));
    return (n > 255) ? 255 : n;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      dac_ready = ($urandom % 3) != 0;
      res_ready = ($urandom % 4) != 0;
      if (dac_valid && dac_ready) begin
        if (dac_code != 12'(hs_cnt * 16)) begin
          if (dac_bad == 0) $display("FAIL R2: actual %0d expected %0d", dac_code, hs_cnt * 16);
          dac_bad++;
        end
        lvl_b = hs_cnt;
        hs_cnt++;
        gap = 0;
        gap_armed = 1;
      end else gap++;
      if (cmp_latch) begin
        latch_cnt++;
        if (phase_req) settle_bad++;
        if (gap_armed) begin
          if (gap != int'(settle_in) + 2) settle_bad++;
          gap_armed = 0;
        end
      end
      if (done) done_cnt++;
      if (res_valid && done_cnt == 0) order_bad++;
      if (res_valid && res_ready) begin
        check(res_code == 8'(exp_code(rx_idx)), "R6 code", res_code, exp_code(rx_idx));
        if (res_phase != 6'(rx_idx) || res_last != (rx_idx == NPH - 1)) rx_bad++;
        rx_idx++;
      end
      if (phase_ack) phase_ack = 0;
      else if (phase_req) begin
        if (ack_wait == 0) begin
          phase_ack = 1;
          ack_cnt++;
          ph_b = (ph_b + 1) % NPH;
          ack_wait = $urandom % 3;
        end else ack_wait--;
      end
      cmp_in = cmp_model(lvl_b, ph_b);
    end
  end

  task automatic pulse_start();
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_sweep(int settle);
    lvl_b = 0; ph_b = 0; hs_cnt = 0; latch_cnt = 0; ack_cnt = 0; done_cnt = 0;
    rx_idx = 0; gap = 0; ack_wait = 0; settle_bad = 0; dac_bad = 0; order_bad = 0;
    rx_bad = 0; gap_armed = 0;
    settle_in = 6'(settle);
    pulse_start();
    check(busy == 1'b1, "R1 busy after start", busy, 1);
    repeat (300) @(negedge clk);
    pulse_start();                       // R1: ignored mid-sweep
    while (done_cnt == 0) @(negedge clk);
    while (!res_valid) @(negedge clk);
    pulse_start();                       // R1: ignored while draining
    while (busy) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      check(!dac_valid && !busy, "R1 no restart", dac_valid, 0);
    end
    check(hs_cnt == NLV, "R2 transfers", hs_cnt, NLV);
    check(dac_bad == 0, "R2 codes", dac_bad, 0);
    check(settle_bad == 0, "R3 settle/R5 latch", settle_bad, 0);
    check(ack_cnt == NLV * NPH, "R4 steps", ack_cnt, NLV * NPH);
    check(latch_cnt == NLV * NPH, "R5 samples", latch_cnt, NLV * NPH);
    check(done_cnt == 1, "R7 done count", done_cnt, 1);
    check(order_bad == 0, "R7 done first", order_bad, 0);
    check(rx_idx == NPH, "R8 beats", rx_idx, NPH);
    check(rx_bad == 0, "R8 phase/last", rx_bad, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed0017));
    repeat (5) @(negedge clk);
    check(!busy && !done && !dac_valid, "R10 reset ctrl", busy, 0);
    check(!phase_req && !cmp_latch && !res_valid, "R10 reset io", res_valid, 0);
    rst_n = 1;
    @(negedge clk);
    for (int p = 0; p < NPH; p++) thr[p] = $urandom % 257;
    thr[0] = 0; thr[1] = 256; thr[2] = 255; thr[3] = 1; thr[4] = 254;
    mode = 0;
    run_sweep(3);
    mode = 1;                            // R9: low counts after saturated run
    run_sweep(0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule